// File: doc/BRIEF.md
# Frame-Sync Power Sequencer for a Voice Codec Channel

This block decides when a voice codec channel is powered up and when it is powered down. A power-on reset starts it powered down. In that state the power-good flag is low and the enables for the analog output and the transmit data output are low, so both outputs are held at high impedance. The channel wakes on the first frame sync pulse seen on either the transmit or the receive sync input. It only wakes if the power-down pin permits it, which means the pin is either held low or toggling as a clock.

Once awake, the channel watches both frame syncs. If neither shows a rising edge for a programmable number of master clock cycles, the channel powers itself down. The default count is 2048, which is about 1 ms at 2.048 MHz. A steady high level on the power-down pin also forces power-down. After every wake-up, the transmit data enable stays low until the second transmit sync pulse has been seen.

All inputs are sampled in the master clock domain, and every output is registered. The analog bias circuits are outside this block; it only produces enables for them.

Top module: `fsync_pwr_ctrl`

## Requirements
- R1: After reset, `pwr_good`, `analog_en` and `dx_en` are 0. `analog_en` always equals `pwr_good`.
- R2: When `pdn_pin` has been sampled high on PDN_HOLD (default 4) consecutive clock edges, `pwr_good` is 0 after the last of those edges.
- R3: A `pdn_pin` that is low, or that toggles every cycle like a clock, never forces power-down.
- R4: A rising edge (0 then 1 on successive clock samples) on `fsx_i` or `fsr_i` sets `pwr_good` to 1 after the edge that samples the 1, unless R2 forces power-down on that same edge.
- R5: While the power-down condition of R2 holds, frame sync pulses do not power the channel up.
- R6: If no sync rising edge occurs, `pwr_good` drops to 0 exactly TIMEOUT_CYC (default 2048) clock edges after the edge that sampled the last sync rising edge.
- R7: Every sync rising edge on either input restarts the R6 timeout count from zero.
- R8: `dx_en` is 1 only while powered up, and only from the edge that samples the second `fsx_i` rising edge since wake-up. The waking edge counts if it was on `fsx_i`. Rising edges on `fsr_i` do not count.
- R9: Any power-down, whether by timeout or by the pin, clears `dx_en` and restarts the R8 count at zero for the next wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pdn_pin | input | 1 | Power-down pin: a steady high forces power-down; low or a clock permits power-up |
| fsx_i | input | 1 | Transmit frame sync |
| fsr_i | input | 1 | Receive frame sync |
| pwr_good | output | 1 | Channel is powered up |
| analog_en | output | 1 | Analog output enable (0 means high impedance) |
| dx_en | output | 1 | Transmit data output enable (0 means high impedance) |

## Verification
Wake-up is exercised from a transmit pulse and, separately, from a receive pulse. This shows whether only transmit pulses advance the data-enable count. Pulse trains spaced just under the timeout separate a correct restart of the count from one that ignores a sync input. A full silent window checks the exact cycle of the timeout. A toggling power-down pin, a steady high pin, and pulses arriving while the pin is high separate clock tolerance, the hold threshold, and the priority of the pin over the syncs. A wake-up after a forced power-down shows whether the second-pulse count was cleared.

// File: rtl/fspd_pkg.sv
package fspd_pkg;
  typedef enum logic {PS_DOWN = 1'b0, PS_UP = 1'b1} pwr_state_e;
  localparam int unsigned NUM_SYNC = 2;
  localparam int unsigned SYNC_TX  = 0;
  localparam int unsigned SYNC_RX  = 1;
endpackage

// File: rtl/fspd_hold_det.sv
module fspd_hold_det #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic held
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_q;

  // held is true on the edge that samples the HOLD-th consecutive high level
  assign held = pin && (run_q >= LAST);

  always_ff @(posedge clk) begin
    if (rst || !pin) run_q <= '0;
    else if (run_q < LAST) run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/fspd_rise_det.sv
module fspd_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic prev_q;

  assign rise = din && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= din;
  end
endmodule

// File: rtl/fspd_idle_timer.sv
module fspd_idle_timer #(
  parameter int unsigned TIMEOUT_CYC = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] TERM = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && !restart && (cnt_q == TERM);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt_q <= '0;
    else if (cnt_q != TERM)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fspd_tx_gate.sv
module fspd_tx_gate #(
  parameter int unsigned ARM_PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic powered_d,
  input  logic tx_rise,
  output logic dx_en
);
  localparam int unsigned CW = $clog2(ARM_PULSES + 1);
  localparam logic [CW-1:0] ARM = CW'(ARM_PULSES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          dx_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!powered_d)                 cnt_d = '0;
    else if (tx_rise && cnt_q < ARM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dx_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dx_q  <= powered_d && (cnt_d == ARM);
    end
  end

  assign dx_en = dx_q;
endmodule

// File: rtl/fsync_pwr_ctrl.sv
module fsync_pwr_ctrl
  import fspd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 2048,
  parameter int unsigned PDN_HOLD    = 4,
  parameter int unsigned ARM_PULSES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pdn_pin,
  input  logic fsx_i,
  input  logic fsr_i,
  output logic pwr_good,
  output logic analog_en,
  output logic dx_en
);
  logic [NUM_SYNC-1:0] fs_in, fs_rise;
  logic                any_rise, forced, expired, powered_d;
  pwr_state_e          st_q, st_d;
  logic                pg_q, an_q;

  assign fs_in[SYNC_TX] = fsx_i;
  assign fs_in[SYNC_RX] = fsr_i;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_sync
    fspd_rise_det u_rise (
      .clk (clk),
      .rst (rst),
      .din (fs_in[g]),
      .rise(fs_rise[g])
    );
  end

  assign any_rise = |fs_rise;

  fspd_hold_det #(.HOLD(PDN_HOLD)) u_hold (
    .clk (clk),
    .rst (rst),
    .pin (pdn_pin),
    .held(forced)
  );

  fspd_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(any_rise),
    .run    (st_q == PS_UP),
    .expired(expired)
  );

  // pin dominates, then sync activity, then the idle timeout
  always_comb begin
    st_d = st_q;
    if (forced)                        st_d = PS_DOWN;
    else if (any_rise)                 st_d = PS_UP;
    else if (st_q == PS_UP && expired) st_d = PS_DOWN;
  end

  assign powered_d = (st_d == PS_UP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= PS_DOWN;
      pg_q <= 1'b0;
      an_q <= 1'b0;
    end else begin
      st_q <= st_d;
      pg_q <= powered_d;
      an_q <= powered_d;
    end
  end

  fspd_tx_gate #(.ARM_PULSES(ARM_PULSES)) u_txg (
    .clk      (clk),
    .rst      (rst),
    .powered_d(powered_d),
    .tx_rise  (fs_rise[SYNC_TX]),
    .dx_en    (dx_en)
  );

  assign pwr_good  = pg_q;
  assign analog_en = an_q;
endmodule

// File: rtl/fsync_pwr_ctrl_chk.sv
module fsync_pwr_ctrl_chk #(
  parameter int unsigned TIMEOUT_CYC = 2048,
  parameter int unsigned PDN_HOLD    = 4
) (
  input logic clk,
  input logic rst,
  input logic pdn_pin,
  input logic fsx_i,
  input logic fsr_i,
  input logic pwr_good,
  input logic analog_en,
  input logic dx_en
);
  int unsigned hi_run, idle;
  logic        px, pr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= 0;
      idle   <= 0;
      px     <= 1'b0;
      pr     <= 1'b0;
    end else begin
      hi_run <= pdn_pin ? ((hi_run < PDN_HOLD) ? hi_run + 1 : hi_run) : 0;
      if ((fsx_i && !px) || (fsr_i && !pr)) idle <= 0;
      else if (pwr_good)                    idle <= idle + 1;
      else                                  idle <= 0;
      px <= fsx_i;
      pr <= fsr_i;
    end
  end

  // R1
  analog_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    analog_en == pwr_good);

  // R2
  pin_forces_down_chk: assert property (@(posedge clk) disable iff (rst)
    (pdn_pin && hi_run >= PDN_HOLD - 1) |=> !pwr_good);

  // R4
  wake_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good) |-> ($past(fsx_i) || $past(fsr_i)));

  // R6
  idle_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_good |-> (idle < TIMEOUT_CYC));

  // R8
  dx_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
    dx_en |-> pwr_good);

  // R8
  dx_rise_on_tx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dx_en) |-> $past(fsx_i));

  // R9
  dx_off_at_down_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_good) |-> !dx_en);
endmodule

bind fsync_pwr_ctrl fsync_pwr_ctrl_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .PDN_HOLD   (PDN_HOLD)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pdn_pin  (pdn_pin),
  .fsx_i    (fsx_i),
  .fsr_i    (fsr_i),
  .pwr_good (pwr_good),
  .analog_en(analog_en),
  .dx_en    (dx_en)
);

// File: tb/fsync_pwr_ctrl_tb.sv
module fsync_pwr_ctrl_tb;
  localparam int T    = 2048;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pdn_pin = 1'b0, fsx_i = 1'b0, fsr_i = 1'b0;
  logic pwr_good, analog_en, dx_en;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // model state
  int m_hi = 0, m_idle = 0, m_tx = 0, m_pwr = 0, m_px = 0, m_pr = 0;

  always #5 clk = ~clk;

  fsync_pwr_ctrl #(.TIMEOUT_CYC(T), .PDN_HOLD(HOLD)) u_dut (
    .clk(clk), .rst(rst), .pdn_pin(pdn_pin), .fsx_i(fsx_i), .fsr_i(fsr_i),
    .pwr_good(pwr_good), .analog_en(analog_en), .dx_en(dx_en)
  );

  // behavioural reference, one step per clock edge
  always @(posedge clk) begin
    if (rst) begin
      m_hi = 0; m_idle = 0; m_tx = 0; m_pwr = 0; m_px = 0; m_pr = 0;
    end else begin
      bit rx, rr, frc;
      int np;
      rx  = fsx_i && (m_px == 0);
      rr  = fsr_i && (m_pr == 0);
      frc = pdn_pin && (m_hi >= HOLD - 1);
      m_hi = pdn_pin ? m_hi + 1 : 0;
      if (frc)                          np = 0;
      else if (rx || rr)                np = 1;
      else if (m_pwr == 1 && m_idle == T - 1) np = 0;
      else                              np = m_pwr;
      if (rx || rr)       m_idle = 0;
      else if (m_pwr == 1) m_idle = m_idle + 1;
      else                m_idle = 0;
      if (np == 0)             m_tx = 0;
      else if (rx && m_tx < 2) m_tx = m_tx + 1;
      m_pwr = np;
      m_px = fsx_i; m_pr = fsr_i;
    end
  end

  task automatic check(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, "pwr_good", int'(pwr_good), m_pwr);
      check("R1", "analog_en", int'(analog_en), m_pwr);
      check(cur_req, "dx_en", int'(dx_en), (m_pwr == 1 && m_tx == 2) ? 1 : 0);
    end
  end

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_x();
    fsx_i = 1'b1; @(negedge clk); fsx_i = 1'b0;
  endtask

  task automatic pulse_r();
    fsr_i = 1'b1; @(negedge clk); fsr_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    check("R1", "reset pwr_good", int'(pwr_good), 0);
    check("R1", "reset dx_en", int'(dx_en), 0);
    wait_n(10);

    // R4 wake on transmit sync; R8 first pulse keeps dx off
    cur_req = "R4";
    pulse_x();
    check("R4", "wake by fsx", int'(pwr_good), 1);
    check("R8", "dx after 1st fsx", int'(dx_en), 0);
    wait_n(20);
    cur_req = "R8";
    pulse_x();
    check("R8", "dx after 2nd fsx", int'(dx_en), 1);

    // R6 exact timeout
    cur_req = "R6";
    wait_n(T - 1);
    check("R6", "just before timeout", int'(pwr_good), 1);
    wait_n(1);
    check("R6", "at timeout", int'(pwr_good), 0);
    check("R9", "dx cleared at timeout", int'(dx_en), 0);
    wait_n(15);

    // R4 wake on receive sync; R8 receive pulses do not count
    cur_req = "R4";
    pulse_r();
    check("R4", "wake by fsr", int'(pwr_good), 1);
    wait_n(9);
    cur_req = "R8";
    pulse_r();
    check("R8", "dx after fsr pulses", int'(dx_en), 0);
    wait_n(9);
    pulse_x();
    check("R8", "dx after 1st fsx post fsr wake", int'(dx_en), 0);
    wait_n(9);
    pulse_x();
    check("R8", "dx after 2nd fsx post fsr wake", int'(dx_en), 1);

    // R7 restarts by either sync, gaps below the timeout
    cur_req = "R7";
    for (int k = 0; k < 4; k++) begin
      wait_n(T - 100);
      if (k % 2 == 0) pulse_r(); else pulse_x();
      check("R7", "still up after near-timeout gap", int'(pwr_good), 1);
    end

    // R3 toggling pin acts as a clock and never forces down
    cur_req = "R3";
    for (int k = 0; k < 300; k++) begin
      pdn_pin = ~pdn_pin;
      if (k % 50 == 0) fsx_i = 1'b1; else fsx_i = 1'b0;
      @(negedge clk);
    end
    fsx_i = 1'b0;
    pdn_pin = 1'b0;
    check("R3", "up with toggling pin", int'(pwr_good), 1);
    wait_n(2);

    // R2 steady high pin
    cur_req = "R2";
    pdn_pin = 1'b1;
    wait_n(HOLD - 1);
    check("R2", "before hold met", int'(pwr_good), 1);
    wait_n(1);
    check("R2", "after hold met", int'(pwr_good), 0);
    check("R9", "dx cleared by pin", int'(dx_en), 0);

    // R5 pulses ignored while pin is high
    cur_req = "R5";
    pulse_x(); wait_n(3);
    pulse_r(); wait_n(3);
    pulse_x();
    check("R5", "no wake with pin high", int'(pwr_good), 0);
    check("R5", "dx stays off with pin high", int'(dx_en), 0);

    // R9 count restarted for next wake
    cur_req = "R9";
    pdn_pin = 1'b0;
    wait_n(5);
    pulse_x();
    check("R9", "wake after forced down", int'(pwr_good), 1);
    check("R9", "dx off after first fsx of new wake", int'(dx_en), 0);
    wait_n(5);
    pulse_x();
    check("R9", "dx on after second fsx of new wake", int'(dx_en), 1);
    wait_n(5);
    finish_run();
  end
endmodule